// File: doc/BRIEF.md
# Calorimeter Trigger Primitive Generator

This block reduces a frame of digitized calorimeter samples into coarse tower energies for a first-level trigger. On every accepted frame, each of 64 channels subtracts a sample it received a programmable number of frames earlier. Any negative result is forced to zero. The upper bits of the resulting difference address a calibration lookup table, which slow control can rewrite while the block is running. The calibrated energies of each group of four neighbouring channels are added, and the top bits of each of the 16 group sums are kept. Together they form one 128-bit trigger word.

The trigger word is launched towards the link FIFO at one selectable fast-clock phase within each beam crossing, as eight 16-bit beats. The input side follows the digitizer and cannot be stalled, so `s_valid` has no ready partner. The output is a valid/ready stream. Once `m_valid` is high, it stays high with `m_data` and `m_last` unchanged until `m_ready` is seen high at a clock edge. A frame is never interrupted. While a frame is still being sent, or while no launch phase has come, a newer trigger word replaces the one still waiting. Each trigger word is sent at most once.

Top module: `trig_prim_gen`

## Requirements
- R1: After reset, `m_valid` is low and remains low until a sample frame has been accepted and a launch has taken place.
- R2: For channel c, the baseline is the sample that channel received `delay_sel` accepted frames before the current one, where a setting of 0 stands for 8 frames. A slot that has not yet been written since reset reads as zero.
- R3: When the baseline is greater than or equal to the current sample, the difference is zero. Otherwise it is the current sample minus the baseline (14 bits).
- R4: Bits 13..4 of the difference address a 1024 x 10-bit table that is written through `lut_we`/`lut_addr`/`lut_wdata`. A frame reads the table on the clock edge one cycle after that frame is accepted, and it sees the contents as they were before any write on that same edge.
- R5: Sum k adds the table outputs of channels 4k to 4k+3 into 12 bits, and keeps bits 11..4 as an 8-bit value.
- R6: Sum k occupies bits 8k+7..8k of the 128-bit word. A frame is 8 beats. Beat j carries word bits 16j+15..16j, beat 0 comes first, and `m_last` is high only on beat 7.
- R7: A frame starts with `m_valid` rising in the cycle after a clock edge where `fast_phase` equals `trig_phase`. Settings 12 to 15 never launch.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold. Beats advance only on a handshake, and they follow each other without gaps when `m_ready` stays high.
- R9: Of several words produced before a launch, only the newest is sent, and each word is sent once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | A sample frame is present this cycle |
| s_samples | input | 896 | 64 samples of 14 bits, channel c at bits 14c+13..14c |
| delay_sel | input | 3 | Baseline distance in frames (0 means 8) |
| fast_phase | input | 4 | Current fast-clock phase within the crossing, 0..11 |
| trig_phase | input | 4 | Phase that launches a frame |
| lut_we | input | 1 | Calibration table write strobe |
| lut_addr | input | 10 | Calibration table write address |
| lut_wdata | input | 10 | Calibration table write data |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Link FIFO accepts the beat |
| m_data | output | 16 | Output beat |
| m_last | output | 1 | Final beat of a frame |

## Verification
The hardest case to reach is a table write on exactly the edge where a frame's sums are captured. From the ports this edge is only one cycle wide, so the stimulus drives the write strobe in the cycle right after the frame is accepted, at an address that frame is known to use, and expects the old entry in the result. Replacement of a waiting word is reached by first parking `trig_phase` at an unreachable value while two frames are produced, then moving it to a live phase. Back-pressure is held off across a launch, and the beat is watched for several cycles.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int PHASES  = 12;
  localparam int PHASE_W = 4;
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/tpg_chan_base.sv
module tpg_chan_base #(
  parameter int SW    = 14,
  parameter int HAW   = 3,
  parameter int IDXW  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SW-1:0]   sample,
  input  logic [HAW-1:0]  wptr,
  input  logic [HAW-1:0]  delay,
  output logic [IDXW-1:0] idx_q
);
  localparam int DEPTH = 1 << HAW;

  logic [SW-1:0]  hist [DEPTH];
  logic [HAW-1:0] raddr;
  logic [SW-1:0]  base;
  logic [SW-1:0]  diff;

  // delay 0 wraps onto the slot about to be overwritten: DEPTH frames back
  assign raddr = wptr - delay;
  assign base  = hist[raddr];
  assign diff  = (sample > base) ? (sample - base) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      idx_q <= '0;
    end else if (in_valid) begin
      hist[wptr] <= sample;
      idx_q      <= diff[SW-1 -: IDXW];
    end
  end
endmodule

// File: rtl/tpg_lut.sv
module tpg_lut #(
  parameter int NCH = 64,
  parameter int LAW = 10,
  parameter int LDW = 10
) (
  input  logic               clk,
  input  logic               we,
  input  logic [LAW-1:0]     waddr,
  input  logic [LDW-1:0]     wdata,
  input  logic [NCH*LAW-1:0] idx,
  output logic [NCH*LDW-1:0] energy
);
  localparam int ENTRIES = 1 << LAW;

  logic [LDW-1:0] table_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) table_q[waddr] <= wdata;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_rd
    assign energy[c*LDW +: LDW] = table_q[idx[c*LAW +: LAW]];
  end
endmodule

// File: rtl/tpg_sum.sv
module tpg_sum #(
  parameter int NCH  = 64,
  parameter int GRP  = 4,
  parameter int LDW  = 10,
  parameter int OUTW = 8,
  localparam int NSUM = NCH / GRP,
  localparam int SUMW = LDW + $clog2(GRP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NCH*LDW-1:0]   energy,
  output logic [NSUM*OUTW-1:0] word_q,
  output logic                 word_pulse
);
  logic [NSUM*OUTW-1:0] word_d;

  for (genvar k = 0; k < NSUM; k++) begin : g_grp
    logic [SUMW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int m = 0; m < GRP; m++)
        acc = acc + SUMW'(energy[(k*GRP+m)*LDW +: LDW]);
    end
    assign word_d[k*OUTW +: OUTW] = acc[SUMW-1 -: OUTW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q     <= '0;
      word_pulse <= 1'b0;
    end else begin
      word_pulse <= in_valid;
      if (in_valid) word_q <= word_d;
    end
  end
endmodule

// File: rtl/tpg_link_ser.sv
module tpg_link_ser
  import tpg_pkg::*;
#(
  parameter int WORDW = 128,
  parameter int BEATW = 16,
  localparam int NBEAT = WORDW / BEATW,
  localparam int CW    = $clog2(NBEAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WORDW-1:0] word,
  input  logic             word_pulse,
  input  phase_t           fast_phase,
  input  phase_t           trig_phase,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [BEATW-1:0] m_data,
  output logic             m_last
);
  logic             pend;
  logic             busy;
  logic [CW-1:0]    cnt;
  logic [WORDW-1:0] hold;
  logic             avail;
  logic             launch;
  logic             fire;

  assign avail  = pend | word_pulse;
  assign launch = avail && !busy && (fast_phase == trig_phase) && (trig_phase < phase_t'(PHASES));
  assign fire   = busy && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      busy <= 1'b0;
      cnt  <= '0;
      hold <= '0;
    end else begin
      pend <= avail && !launch;
      if (launch) begin
        busy <= 1'b1;
        cnt  <= '0;
        hold <= word;
      end else if (fire) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(NBEAT-1)) busy <= 1'b0;
      end
    end
  end

  assign m_valid = busy;
  assign m_data  = hold[cnt*BEATW +: BEATW];
  assign m_last  = busy && (cnt == CW'(NBEAT-1));
endmodule

// File: rtl/trig_prim_gen.sv
module trig_prim_gen
  import tpg_pkg::*;
#(
  parameter int NCH   = 64,
  parameter int SW    = 14,
  parameter int HAW   = 3,
  parameter int LAW   = 10,
  parameter int LDW   = 10,
  parameter int GRP   = 4,
  parameter int OUTW  = 8,
  parameter int BEATW = 16,
  localparam int NSUM  = NCH / GRP,
  localparam int WORDW = NSUM * OUTW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [NCH*SW-1:0] s_samples,
  input  logic [HAW-1:0]    delay_sel,
  input  logic [3:0]        fast_phase,
  input  logic [3:0]        trig_phase,
  input  logic              lut_we,
  input  logic [LAW-1:0]    lut_addr,
  input  logic [LDW-1:0]    lut_wdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BEATW-1:0]  m_data,
  output logic              m_last
);
  logic [HAW-1:0]     wptr;
  logic               v1;
  logic [NCH*LAW-1:0] idx;
  logic [NCH*LDW-1:0] energy;
  logic [WORDW-1:0]   word_q;
  logic               word_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      v1   <= 1'b0;
    end else begin
      v1 <= s_valid;
      if (s_valid) wptr <= wptr + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tpg_chan_base #(.SW(SW), .HAW(HAW), .IDXW(LAW)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (s_valid),
      .sample   (s_samples[c*SW +: SW]),
      .wptr     (wptr),
      .delay    (delay_sel),
      .idx_q    (idx[c*LAW +: LAW])
    );
  end

  tpg_lut #(.NCH(NCH), .LAW(LAW), .LDW(LDW)) u_lut (
    .clk    (clk),
    .we     (lut_we),
    .waddr  (lut_addr),
    .wdata  (lut_wdata),
    .idx    (idx),
    .energy (energy)
  );

  tpg_sum #(.NCH(NCH), .GRP(GRP), .LDW(LDW), .OUTW(OUTW)) u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (v1),
    .energy     (energy),
    .word_q     (word_q),
    .word_pulse (word_pulse)
  );

  tpg_link_ser #(.WORDW(WORDW), .BEATW(BEATW)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .word       (word_q),
    .word_pulse (word_pulse),
    .fast_phase (phase_t'(fast_phase)),
    .trig_phase (phase_t'(trig_phase)),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data),
    .m_last     (m_last)
  );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int BEATW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             m_valid,
  input logic             m_ready,
  input logic [BEATW-1:0] m_data,
  input logic             m_last,
  input logic [3:0]       fast_phase,
  input logic [3:0]       trig_phase
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid); // R8
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> ($stable(m_data) && $stable(m_last))); // R8
  AST_LAUNCH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> ($past(fast_phase) == $past(trig_phase))); // R7
  AST_FRAME_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !m_last) |=> m_valid); // R6
  AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_valid) |-> $past(m_last && m_ready)); // R6
  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid); // R6
endmodule

bind trig_prim_gen tpg_checker #(.BEATW(BEATW)) u_tpg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_data     (m_data),
  .m_last     (m_last),
  .fast_phase (fast_phase),
  .trig_phase (trig_phase)
);

// File: tb/test_trig_prim_gen.sv
`timescale 1ns/1ps
module test_trig_prim_gen;
  localparam int NCH = 64;
  localparam int SW  = 14;
  localparam int NV  = 8;
  localparam int VEC_BASE [NV] = '{100, 5000, 16383, 0, 9000, 12000, 300, 16000};
  localparam int VEC_STEP [NV] = '{37, 211, 0, 0, 97, 5, 400, 1};

  logic              clk = 0;
  logic              rst_n = 0;
  logic              s_valid = 0;
  logic [NCH*SW-1:0] s_samples = '0;
  logic [2:0]        delay_sel = 3'd3;
  logic [3:0]        fast_phase = 0;
  logic [3:0]        trig_phase = 4'd4;
  logic              lut_we = 0;
  logic [9:0]        lut_addr = 0;
  logic [9:0]        lut_wdata = 0;
  logic              m_valid;
  logic              m_ready = 1;
  logic [15:0]       m_data;
  logic              m_last;

  int errors = 0;
  int checks = 0;
  logic [13:0]  hist [64][NCH];
  int           nsent = 0;
  logic [9:0]   blut [1024];
  logic [127:0] expw;

  always #5 clk = ~clk;

  always @(posedge clk) fast_phase <= !rst_n ? 4'd0 : (fast_phase == 4'd11 ? 4'd0 : fast_phase + 4'd1);

  trig_prim_gen i_trig_prim_gen (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_samples(s_samples),
    .delay_sel(delay_sel), .fast_phase(fast_phase), .trig_phase(trig_phase),
    .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_word(input int n);
    logic [127:0] w;
    int d;
    d = (delay_sel == 0) ? 8 : int'(delay_sel);
    for (int k = 0; k < 16; k++) begin
      int s;
      s = 0;
      for (int c = 4*k; c < 4*k+4; c++) begin
        int cur, e, df;
        cur = int'(hist[n][c]);
        e   = (n - d >= 0) ? int'(hist[n-d][c]) : 0;
        df  = (cur > e) ? cur - e : 0;          // R3 clamp
        s  += int'(blut[df >> 4]);              // R4 index from bits 13..4
      end
      w[8*k +: 8] = 8'((s >> 4) & 255);         // R5 upper 8 of 12
    end
    return w;
  endfunction

  // drive a frame; lut_after optionally writes the table on the sum-capture edge
  task automatic send(input int base, input int step, input bit lut_after,
                      input logic [9:0] la, input logic [9:0] ld);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      hist[nsent][c] = 14'((base + c*step) % 16384);
      s_samples[c*SW +: SW] = hist[nsent][c];
    end
    s_valid = 1;
    expw = model_word(nsent);
    nsent++;
    @(negedge clk);
    s_valid = 0;
    if (lut_after) begin
      lut_we = 1; lut_addr = la; lut_wdata = ld;
      @(negedge clk);
      lut_we = 0;
      blut[la] = ld;
    end
  endtask

  task automatic collect(input logic [127:0] w, input bit phase_chk, input string tag);
    int t;
    t = 0;
    while (!m_valid && t < 60) begin @(negedge clk); t++; end
    chk(m_valid, {tag, " R7 launch"}, 128'(m_valid), 128'(1));
    if (phase_chk)
      chk(fast_phase == 4'((trig_phase + 1) % 12), {tag, " R7 phase"}, 128'(fast_phase),
          128'((trig_phase + 1) % 12));
    for (int j = 0; j < 8; j++) begin
      chk(m_valid, {tag, " R8 no gap"}, 128'(m_valid), 128'(1));
      chk(m_data == w[16*j +: 16], {tag, " R6 beat data"}, 128'(m_data), 128'(w[16*j +: 16]));
      chk(m_last == (j == 7), {tag, " R6 last"}, 128'(m_last), 128'(j == 7));
      @(negedge clk);
    end
  endtask

  task automatic idle_check(input int n, input string req);
    bit seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (m_valid) seen = 1; end
    chk(!seen, req, 128'(seen), 128'(0));
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] w1, w2, held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset
    idle_check(20, "R1 idle after reset");

    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      lut_we = 1; lut_addr = 10'(a); lut_wdata = 10'(a);
      blut[a] = 10'(a);
    end
    @(negedge clk); lut_we = 0;

    // table walk: R2 history, R3 clamp (entry 3), R5 saturation (entry 2), R6 packing
    for (int v = 0; v < NV; v++) begin
      send(VEC_BASE[v], VEC_STEP[v], 0, '0, '0);
      collect(expw, 1, $sformatf("vec%0d R2 R3 R5", v));
    end

    // R7: unreachable phase never launches; R9: newest word only, sent once
    trig_phase = 4'd15;
    send(2000, 13, 0, '0, '0); w1 = expw;
    send(7000, 29, 0, '0, '0); w2 = expw;
    idle_check(30, "R7 phase 15 no launch");
    @(negedge clk); trig_phase = 4'd5;
    collect(w2, 1, "R9 newest word");
    chk(w1 != w2, "R9 words distinct", w1, w2);
    idle_check(30, "R9 sent once");

    // R8: back-pressure holds the first beat
    m_ready = 0;
    send(11000, 3, 0, '0, '0);
    while (!m_valid) @(negedge clk);
    held = 128'(m_data);
    repeat (4) begin
      @(negedge clk);
      chk(m_valid && m_data == held[15:0] && !m_last, "R8 stall hold", 128'(m_data), held);
    end
    m_ready = 1;
    collect(expw, 0, "R8 release");

    // R4: write on the capture edge leaves the old entry in use
    begin
      int cur, e, df;
      cur = 15000;
      e   = int'(hist[nsent-3][0]);
      df  = (cur > e) ? cur - e : 0;
      send(15000, 0, 1, 10'(df >> 4), 10'd0);
      collect(expw, 1, "R4 same-edge write old");
    end
    // R4: next frame sees a rewritten entry
    @(negedge clk); lut_we = 1; lut_addr = 10'd1023; lut_wdata = 10'd1; blut[1023] = 10'd1;
    @(negedge clk); lut_we = 0;
    for (int i = 0; i < 8; i++) begin send(0, 0, 0, '0, '0); collect(expw, 1, "R4 prefill"); end
    send(16383, 0, 0, '0, '0);
    chk(expw == {16{8'd0}}, "R4 new entry model", expw, '0);
    collect(expw, 1, "R4 new entry used");

    // R2: delay setting 0 reaches back 8 frames
    delay_sel = 3'd0;
    send(500, 41, 0, '0, '0);
    collect(expw, 1, "R2 delay zero is eight");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule